// File: doc/BRIEF.md
# Receive Frame Rule Classifier

This block sorts each received Ethernet frame using eight programmable rules. Frame bytes arrive one per cycle, with start and end markers. Side inputs give the byte positions where the IP, TCP and UDP headers begin, each with a present flag, and the position where the payload begins. Each rule takes a 32-bit window from the frame. The window starts at a chosen base plus a byte offset. The rule compares that window against its value word using one of four operators, or, in mask mode, it compares only 16 bits under a mask.

Rules can be joined into AND chains. Among the single rules and chains, the lowest-indexed one that holds decides the outcome. One cycle after the last byte, the block reports:

- whether any rule matched,
- the class the frame goes to,
- whether the frame should be dropped,
- three processor-activation flags.

The header positions and the rule configuration must stay stable while a frame is in flight. Header parsing, queue placement and register access are outside this block.

Top module: `rx_rule_classifier`

## Requirements
- R1: A rule's control word has an enable bit at bit 31. Bits 17:16 pick the operator: 00 equal, 01 not equal, 10 captured word greater than value, 11 captured word less than value. All compares are unsigned.
- R2: Control bits 15:13 pick the window base and bits 7:0 give the byte offset added to it. The base codes are: 000 frame start (position 0), 001 IP header, 010 TCP header, 011 UDP header, 100 payload start. IP, TCP and UDP count only when their present flag is high. A rule whose base is absent, or whose code is 101 to 111, is false.
- R3: A rule whose four-byte window extends beyond the last byte of the frame is false.
- R4: Captured bytes are packed big-endian. The byte at the window start lands in bits 31:24. The first byte of a frame is at position 0.
- R5: With control bit 26 set, the value word splits into a mask in bits 31:16 and a value in bits 15:0. The rule compares (captured bits 31:16 AND mask) against (value AND mask), using the selected operator.
- R6: With control bit 30 set, the rule holds only if the following rule also holds. A disabled following rule counts as true. Chains may span several rules. A rule whose predecessor has bit 30 set is judged only as part of that chain, never on its own. Class, drop and activation come from the first rule of the chain.
- R7: Bits 12:8 carry the class reported for a match. A match drops the frame when control bit 25 is set or when its class is 0.
- R8: Control bits 29, 28 and 27 are processor flags 1, 2 and 3. For a match they appear on `res_act` bits 0, 1 and 2.
- R9: When several rules or chains hold, the one with the lowest index decides.
- R10: When nothing matches, `res_hit` is 0, the class is 1, the frame is not dropped and the flags are 0.
- R11: `res_valid` pulses high for exactly the one cycle after the end-of-frame byte. While `res_valid` is low, all result outputs are 0.
- R12: A rule with its enable bit clear never matches on its own, even when its compare would hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_ctrl | input | 32*NUM_RULES | Control words, rule i in bits 32*i+31:32*i |
| cfg_val | input | 32*NUM_RULES | Value/mask words, packed like cfg_ctrl |
| in_valid | input | 1 | Byte strobe |
| in_sof | input | 1 | Current byte is the first of a frame |
| in_eof | input | 1 | Current byte is the last of a frame |
| in_byte | input | 8 | Frame byte |
| ip_present | input | 1 | IP header exists in this frame |
| ip_base | input | POS_W | Byte position of the IP header |
| tcp_present | input | 1 | TCP header exists |
| tcp_base | input | POS_W | Byte position of the TCP header |
| udp_present | input | 1 | UDP header exists |
| udp_base | input | POS_W | Byte position of the UDP header |
| data_base | input | POS_W | Byte position of the payload |
| res_valid | output | 1 | Result strobe |
| res_hit | output | 1 | Some rule or chain matched |
| res_discard | output | 1 | Drop the frame |
| res_class | output | 5 | Class of the frame |
| res_act | output | 3 | Processor activation flags 1..3 in bits 0..2 |

## Verification
Every rule's state lives in its capture register and byte count, and both are rebuilt for each frame. A wrong position count or a shift out of order shows up at the ports as a changed class or hit on the very frame it affects, in the cycle after the end byte. A byte count that stops one short turns a matching window into a miss, so boundary frames with the window at the last bytes are exercised. A fault in chain or priority resolution shows as the wrong rule's class or flags on frames where two rules hold at once.

// File: rtl/rxc_pkg.sv
package rxc_pkg;
  localparam int WORD_W = 32;
  localparam int CLS_W  = 5;

  typedef enum logic [1:0] {
    OP_EQ = 2'b00,
    OP_NE = 2'b01,
    OP_GT = 2'b10,
    OP_LT = 2'b11
  } cmp_op_e;

  typedef enum logic [2:0] {
    BASE_FRAME = 3'b000,
    BASE_IP    = 3'b001,
    BASE_TCP   = 3'b010,
    BASE_UDP   = 3'b011,
    BASE_DATA  = 3'b100
  } base_sel_e;

  typedef struct packed {
    logic             enable;    // 31
    logic             and_next;  // 30
    logic [2:0]       act;       // 29 proc1, 28 proc2, 27 proc3
    logic             half_mask; // 26
    logic             drop;      // 25
    logic             spare;     // 24
    logic [5:0]       rsvd;      // 23:18
    cmp_op_e          op;        // 17:16
    base_sel_e        base;      // 15:13
    logic [CLS_W-1:0] cls;       // 12:8
    logic [7:0]       offset;    // 7:0
  } rule_ctrl_t;
endpackage

// File: rtl/rxc_rule_capture.sv
module rxc_rule_capture
  import rxc_pkg::*;
#(
  parameter int POS_W = 11,
  localparam int PW = POS_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              in_sof,
  input  logic [7:0]        in_byte,
  input  logic [PW-1:0]     cur_pos,
  input  rule_ctrl_t        ctrl,
  input  logic              ip_present,
  input  logic [POS_W-1:0]  ip_base,
  input  logic              tcp_present,
  input  logic [POS_W-1:0]  tcp_base,
  input  logic              udp_present,
  input  logic [POS_W-1:0]  udp_base,
  input  logic [POS_W-1:0]  data_base,
  output logic [WORD_W-1:0] word_nx,
  output logic              full_nx,
  output logic              base_ok
);
  logic [POS_W-1:0]  base_pos;
  logic [PW-1:0]     win_lo, win_hi;
  logic              in_win;
  logic [WORD_W-1:0] word_q, word_start;
  logic [2:0]        cnt_q, cnt_start, cnt_nx;

  always_comb begin
    base_ok  = 1'b1;
    base_pos = '0;
    unique case (ctrl.base)
      BASE_FRAME: base_pos = '0;
      BASE_IP:    begin base_pos = ip_base;  base_ok = ip_present;  end
      BASE_TCP:   begin base_pos = tcp_base; base_ok = tcp_present; end
      BASE_UDP:   begin base_pos = udp_base; base_ok = udp_present; end
      BASE_DATA:  base_pos = data_base;
      default:    base_ok = 1'b0;
    endcase
  end

  assign win_lo = PW'(base_pos) + PW'(ctrl.offset);
  assign win_hi = win_lo + PW'(4);
  assign in_win = (cur_pos >= win_lo) && (cur_pos < win_hi);

  always_comb begin
    word_start = in_sof ? '0 : word_q;
    cnt_start  = in_sof ? '0 : cnt_q;
    word_nx    = word_q;
    cnt_nx     = cnt_q;
    if (in_valid) begin
      word_nx = word_start;
      cnt_nx  = cnt_start;
      if (in_win) begin
        word_nx = {word_start[WORD_W-9:0], in_byte};
        cnt_nx  = cnt_start + 3'd1;
      end
    end
  end

  assign full_nx = (cnt_nx == 3'd4);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
      cnt_q  <= '0;
    end else if (in_valid) begin
      word_q <= word_nx;
      cnt_q  <= cnt_nx;
    end
  end
endmodule

// File: rtl/rxc_rule_compare.sv
module rxc_rule_compare
  import rxc_pkg::*;
(
  input  rule_ctrl_t        ctrl,
  input  logic [WORD_W-1:0] val,
  input  logic [WORD_W-1:0] word,
  input  logic              full,
  input  logic              base_ok,
  output logic              holds
);
  logic [WORD_W-1:0] lhs, rhs;
  logic              cmp;

  always_comb begin
    if (ctrl.half_mask) begin
      lhs = {16'h0, word[31:16] & val[31:16]};
      rhs = {16'h0, val[15:0]   & val[31:16]};
    end else begin
      lhs = word;
      rhs = val;
    end
    unique case (ctrl.op)
      OP_EQ: cmp = (lhs == rhs);
      OP_NE: cmp = (lhs != rhs);
      OP_GT: cmp = (lhs >  rhs);
      OP_LT: cmp = (lhs <  rhs);
      default: cmp = 1'b0;
    endcase
  end

  assign holds = ctrl.enable && full && base_ok && cmp;
endmodule

// File: rtl/rxc_resolve.sv
module rxc_resolve
  import rxc_pkg::*;
#(
  parameter int NUM_RULES = 8
) (
  input  rule_ctrl_t [NUM_RULES-1:0] ctrl,
  input  logic       [NUM_RULES-1:0] holds,
  output logic                       hit,
  output logic                       discard,
  output logic       [CLS_W-1:0]     cls,
  output logic       [2:0]           act
);
  logic [NUM_RULES-1:0] tail_ok, head, match;

  always_comb begin
    tail_ok[NUM_RULES-1] = ctrl[NUM_RULES-1].enable ? holds[NUM_RULES-1] : 1'b1;
    for (int i = NUM_RULES - 2; i >= 0; i--) begin
      tail_ok[i] = (ctrl[i].enable ? holds[i] : 1'b1) &&
                   (ctrl[i].and_next ? tail_ok[i+1] : 1'b1);
    end
    for (int i = 0; i < NUM_RULES; i++) begin
      head[i]  = (i == 0) ? 1'b1 : !ctrl[(i == 0) ? 0 : i-1].and_next;
      match[i] = head[i] && holds[i] &&
                 ((ctrl[i].and_next && i < NUM_RULES - 1) ?
                  tail_ok[(i < NUM_RULES - 1) ? i+1 : i] : 1'b1);
    end
  end

  always_comb begin
    hit     = 1'b0;
    discard = 1'b0;
    cls     = CLS_W'(1);
    act     = '0;
    for (int i = NUM_RULES - 1; i >= 0; i--) begin
      if (match[i]) begin
        hit     = 1'b1;
        cls     = ctrl[i].cls;
        discard = ctrl[i].drop || (ctrl[i].cls == '0);
        act     = {ctrl[i].act[0], ctrl[i].act[1], ctrl[i].act[2]};
      end
    end
  end
endmodule

// File: rtl/rx_rule_classifier.sv
module rx_rule_classifier
  import rxc_pkg::*;
#(
  parameter int NUM_RULES = 8,
  parameter int POS_W     = 11
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NUM_RULES*WORD_W-1:0] cfg_ctrl,
  input  logic [NUM_RULES*WORD_W-1:0] cfg_val,
  input  logic                        in_valid,
  input  logic                        in_sof,
  input  logic                        in_eof,
  input  logic [7:0]                  in_byte,
  input  logic                        ip_present,
  input  logic [POS_W-1:0]            ip_base,
  input  logic                        tcp_present,
  input  logic [POS_W-1:0]            tcp_base,
  input  logic                        udp_present,
  input  logic [POS_W-1:0]            udp_base,
  input  logic [POS_W-1:0]            data_base,
  output logic                        res_valid,
  output logic                        res_hit,
  output logic                        res_discard,
  output logic [CLS_W-1:0]            res_class,
  output logic [2:0]                  res_act
);
  localparam int PW = POS_W + 2;

  logic [PW-1:0]              pos_q, pos_cur;
  rule_ctrl_t [NUM_RULES-1:0] ctrl;
  logic [NUM_RULES-1:0]       holds;
  logic                       r_hit, r_disc;
  logic [CLS_W-1:0]           r_cls;
  logic [2:0]                 r_act;
  logic                       done;
  logic                       hit_nx, disc_nx;
  logic [CLS_W-1:0]           cls_nx;
  logic [2:0]                 act_nx;

  assign pos_cur = in_sof ? '0 : pos_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        pos_q <= '0;
    else if (in_valid) pos_q <= pos_cur + PW'(1);
  end

  for (genvar g = 0; g < NUM_RULES; g++) begin : g_rule
    logic [WORD_W-1:0] word_nx;
    logic              full_nx, base_ok;

    assign ctrl[g] = rule_ctrl_t'(cfg_ctrl[g*WORD_W +: WORD_W]);

    rxc_rule_capture #(.POS_W(POS_W)) u_cap (
      .clk, .rst_n, .in_valid, .in_sof, .in_byte,
      .cur_pos(pos_cur), .ctrl(ctrl[g]),
      .ip_present, .ip_base, .tcp_present, .tcp_base,
      .udp_present, .udp_base, .data_base,
      .word_nx, .full_nx, .base_ok
    );

    rxc_rule_compare u_cmp (
      .ctrl(ctrl[g]), .val(cfg_val[g*WORD_W +: WORD_W]),
      .word(word_nx), .full(full_nx), .base_ok,
      .holds(holds[g])
    );
  end

  rxc_resolve #(.NUM_RULES(NUM_RULES)) u_res (
    .ctrl, .holds, .hit(r_hit), .discard(r_disc), .cls(r_cls), .act(r_act)
  );

  always_comb begin
    done    = in_valid && in_eof;
    hit_nx  = done && r_hit;
    disc_nx = done && r_disc;
    cls_nx  = done ? r_cls : '0;
    act_nx  = done ? r_act : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid   <= 1'b0;
      res_hit     <= 1'b0;
      res_discard <= 1'b0;
      res_class   <= '0;
      res_act     <= '0;
    end else begin
      res_valid   <= done;
      res_hit     <= hit_nx;
      res_discard <= disc_nx;
      res_class   <= cls_nx;
      res_act     <= act_nx;
    end
  end
endmodule

// File: rtl/rxc_checker.sv
module rxc_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       in_valid,
  input logic       in_eof,
  input logic       res_valid,
  input logic       res_hit,
  input logic       res_discard,
  input logic [4:0] res_class,
  input logic [2:0] res_act
);
  // R11
  result_follows_eof_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_eof) |=> res_valid);
  // R11
  result_only_after_eof_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> $past(in_valid && in_eof));
  // R11
  idle_outputs_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |-> (!res_hit && !res_discard && res_class == 5'd0 && res_act == 3'd0));
  // R10
  miss_default_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_hit) |-> (res_class == 5'd1 && !res_discard && res_act == 3'd0));
  // R7
  class_zero_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_class == 5'd0) |-> res_discard);
endmodule

bind rx_rule_classifier rxc_checker u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_eof(in_eof),
  .res_valid(res_valid), .res_hit(res_hit), .res_discard(res_discard),
  .res_class(res_class), .res_act(res_act)
);

// File: tb/rx_rule_classifier_tb.sv
module rx_rule_classifier_tb;
  localparam int N  = 8;
  localparam int PW = 11;

  logic          clk, rst_n;
  logic [N*32-1:0] cfg_ctrl, cfg_val;
  logic          in_valid, in_sof, in_eof;
  logic [7:0]    in_byte;
  logic          ip_present, tcp_present, udp_present;
  logic [PW-1:0] ip_base, tcp_base, udp_base, data_base;
  logic          res_valid, res_hit, res_discard;
  logic [4:0]    res_class;
  logic [2:0]    res_act;

  int n_chk = 0;
  int n_err = 0;

  rx_rule_classifier #(.NUM_RULES(N), .POS_W(PW)) u_dut (
    .clk, .rst_n, .cfg_ctrl, .cfg_val, .in_valid, .in_sof, .in_eof, .in_byte,
    .ip_present, .ip_base, .tcp_present, .tcp_base, .udp_present, .udp_base,
    .data_base, .res_valid, .res_hit, .res_discard, .res_class, .res_act
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input bit en, input bit an, input logic [2:0] a,
      input bit msk, input bit drop, input logic [1:0] op, input logic [2:0] hb,
      input logic [4:0] cls, input logic [7:0] off);
    return {en, an, a, msk, drop, 1'b0, 6'b0, op, hb, cls, off};
  endfunction

  task automatic set_rule(input int i, input logic [31:0] c, input logic [31:0] v);
    cfg_ctrl[i*32 +: 32] = c;
    cfg_val[i*32 +: 32]  = v;
  endtask

  task automatic clear_rules();
    cfg_ctrl = '0;
    cfg_val  = '0;
  endtask

  // Bytes are their own position: byte i = i.
  task automatic run_frame(input string req, input int len, input bit e_hit,
      input logic [4:0] e_cls, input bit e_disc, input logic [2:0] e_act);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_sof   = (i == 0);
      in_eof   = (i == len - 1);
      in_byte  = 8'(i);
      if (i == len - 1) chk({req, " R11 no early valid"}, res_valid, 0);
    end
    @(negedge clk);
    in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
    chk({req, " R11 valid"}, res_valid, 1);
    chk({req, " hit"}, res_hit, e_hit);
    chk({req, " class"}, res_class, e_cls);
    chk({req, " discard"}, res_discard, e_disc);
    chk({req, " act"}, res_act, e_act);
    @(negedge clk);
    chk({req, " R11 pulse ends"}, {res_valid, res_class}, 0);
  endtask

  task automatic t_default();
    clear_rules();
    set_rule(0, mk(0, 0, 3'b111, 0, 0, 2'b00, 3'd0, 5'd9, 8'd0), 32'h00010203);
    run_frame("R12 R10 disabled rule", 16, 0, 5'd1, 0, 3'd0);
  endtask

  task automatic t_ops();
    clear_rules();
    set_rule(0, mk(1, 0, 0, 0, 0, 2'b00, 3'd0, 5'd5, 8'd4), 32'h04050607);
    run_frame("R1 R4 equal", 16, 1, 5'd5, 0, 0);
    set_rule(0, mk(1, 0, 0, 0, 0, 2'b01, 3'd0, 5'd5, 8'd4), 32'h04050607);
    run_frame("R1 not equal false", 16, 0, 5'd1, 0, 0);
    set_rule(0, mk(1, 0, 0, 0, 0, 2'b10, 3'd0, 5'd5, 8'd4), 32'h04050606);
    run_frame("R1 greater", 16, 1, 5'd5, 0, 0);
    set_rule(0, mk(1, 0, 0, 0, 0, 2'b11, 3'd0, 5'd5, 8'd4), 32'h04050606);
    run_frame("R1 less false", 16, 0, 5'd1, 0, 0);
    set_rule(0, mk(1, 0, 0, 0, 0, 2'b11, 3'd0, 5'd5, 8'd4), 32'h04050608);
    run_frame("R1 less", 16, 1, 5'd5, 0, 0);
  endtask

  task automatic t_bases();
    clear_rules();
    ip_base = 11'd10; tcp_base = 11'd3; udp_base = 11'd7; data_base = 11'd20;
    ip_present = 1'b1; tcp_present = 1'b1; udp_present = 1'b1;
    set_rule(0, mk(1, 0, 0, 0, 0, 2'b00, 3'd1, 5'd6, 8'd2), 32'h0C0D0E0F);
    run_frame("R2 ip base", 32, 1, 5'd6, 0, 0);
    ip_present = 1'b0;
    run_frame("R2 ip absent", 32, 0, 5'd1, 0, 0);
    set_rule(0, mk(1, 0, 0, 0, 0, 2'b00, 3'd2, 5'd6, 8'd0), 32'h03040506);
    run_frame("R2 tcp base", 32, 1, 5'd6, 0, 0);
    set_rule(0, mk(1, 0, 0, 0, 0, 2'b00, 3'd3, 5'd6, 8'd1), 32'h08090A0B);
    run_frame("R2 udp base", 32, 1, 5'd6, 0, 0);
    set_rule(0, mk(1, 0, 0, 0, 0, 2'b00, 3'd4, 5'd6, 8'd0), 32'h14151617);
    run_frame("R2 data base", 32, 1, 5'd6, 0, 0);
    set_rule(0, mk(1, 0, 0, 0, 0, 2'b00, 3'd5, 5'd6, 8'd0), 32'h00010203);
    run_frame("R2 bad code", 32, 0, 5'd1, 0, 0);
  endtask

  task automatic t_window();
    clear_rules();
    set_rule(0, mk(1, 0, 0, 0, 0, 2'b00, 3'd0, 5'd7, 8'd4), 32'h04050607);
    run_frame("R3 window at end", 8, 1, 5'd7, 0, 0);
    set_rule(0, mk(1, 0, 0, 0, 0, 2'b01, 3'd0, 5'd7, 8'd5), 32'h00000000);
    run_frame("R3 window past end", 8, 0, 5'd1, 0, 0);
  endtask

  task automatic t_mask();
    clear_rules();
    set_rule(0, mk(1, 0, 0, 1, 0, 2'b00, 3'd0, 5'd8, 8'd4), 32'hFF00_0400);
    run_frame("R5 masked equal", 16, 1, 5'd8, 0, 0);
    set_rule(0, mk(1, 0, 0, 1, 0, 2'b00, 3'd0, 5'd8, 8'd4), 32'hFF00_0500);
    run_frame("R5 masked differ", 16, 0, 5'd1, 0, 0);
  endtask

  task automatic t_chain();
    clear_rules();
    set_rule(0, mk(1, 1, 3'b110, 0, 0, 2'b00, 3'd0, 5'd3, 8'd0), 32'h00010203);
    set_rule(1, mk(1, 0, 3'b001, 0, 0, 2'b00, 3'd0, 5'd7, 8'd0), 32'hDEADBEEF);
    run_frame("R6 chain second false", 16, 0, 5'd1, 0, 0);
    set_rule(1, mk(0, 0, 3'b001, 0, 0, 2'b00, 3'd0, 5'd7, 8'd0), 32'hDEADBEEF);
    run_frame("R6 R8 chain disabled next", 16, 1, 5'd3, 0, 3'b011);
    set_rule(1, mk(1, 0, 3'b001, 0, 0, 2'b00, 3'd0, 5'd7, 8'd0), 32'h00010203);
    run_frame("R6 R8 chain both", 16, 1, 5'd3, 0, 3'b011);
    set_rule(0, mk(1, 1, 3'b110, 0, 0, 2'b00, 3'd0, 5'd3, 8'd0), 32'hDEADBEEF);
    run_frame("R6 member not alone", 16, 0, 5'd1, 0, 0);
  endtask

  task automatic t_drop();
    clear_rules();
    set_rule(0, mk(1, 0, 3'b100, 0, 1, 2'b00, 3'd0, 5'd4, 8'd0), 32'h00010203);
    run_frame("R7 R8 drop bit", 16, 1, 5'd4, 1, 3'b001);
    set_rule(0, mk(1, 0, 0, 0, 0, 2'b00, 3'd0, 5'd0, 8'd0), 32'h00010203);
    run_frame("R7 class zero", 16, 1, 5'd0, 1, 0);
  endtask

  task automatic t_priority();
    clear_rules();
    set_rule(2, mk(1, 0, 0, 0, 0, 2'b00, 3'd0, 5'd2, 8'd0), 32'h00010203);
    set_rule(5, mk(1, 0, 0, 0, 0, 2'b00, 3'd0, 5'd9, 8'd1), 32'h01020304);
    run_frame("R9 lowest wins", 16, 1, 5'd2, 0, 0);
    set_rule(2, mk(0, 0, 0, 0, 0, 2'b00, 3'd0, 5'd2, 8'd0), 32'h00010203);
    run_frame("R9 R12 next wins", 16, 1, 5'd9, 0, 0);
  endtask

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0; in_byte = '0;
    ip_present = 1'b0; tcp_present = 1'b0; udp_present = 1'b0;
    ip_base = '0; tcp_base = '0; udp_base = '0; data_base = '0;
    cfg_ctrl = '0; cfg_val = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11 reset state", {res_valid, res_hit, res_discard, res_class, res_act}, 0);
    t_default();
    t_ops();
    t_bases();
    t_window();
    t_mask();
    t_chain();
    t_drop();
    t_priority();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule